// File: doc/BRIEF.md
# Compressed Texture Block Palette Decoder

This block takes one 64-bit compressed colour block and expands it into sixteen 32-bit RGBA texels. The block holds two RGB565 endpoint colours and a 32-bit word of 2-bit texel indices. The decoder widens both endpoints to 8 bits per channel and builds a four-entry palette from them. Each texel then selects one palette entry with its index.

The two interpolated palette entries can be computed with one of three rounding conventions, picked per block by a 2-bit mode input. Mode 0 is an exact-thirds rule with truncating division. Mode 1 is a scaled fixed-point rule that works on the raw 5-bit codes for red and blue and on the expanded values for green. Mode 2 is a 6-bit fixed-point rule with a rounding bias. Each convention also has its own midpoint rule for the three-colour case.

Blocks enter through a valid/ready handshake. Texels leave through a second valid/ready handshake, one texel per transfer in raster order. A new block can be taken in the same cycle that the final texel of the previous block is handed off, so a steady stream loses no cycles between blocks.

Top module: `bc1_block_decoder`

## Requirements
- R1: During and after synchronous active-high reset, `out_valid` is 0 and `in_ready` is 1.
- R2: A block is taken on a cycle with `in_valid` and `in_ready` both high, and `in_mode` is captured with it. While a block is being emitted, `in_ready` is 0, except in the cycle that hands off its sixteenth texel. Block layout: endpoint 0 in bits [15:0], endpoint 1 in [31:16], index word in [63:32]. Each endpoint holds red in [15:11], green in [10:5] and blue in [4:0].
- R3: Each block produces exactly 16 texels, one per cycle with `out_valid` and `out_ready` high. Texel i uses index bits [2i+1:2i] of the index word. `out_texel` packs alpha in [31:24], blue in [23:16], green in [15:8] and red in [7:0].
- R4: Palette entries 0 and 1 are the expanded endpoints 0 and 1. A 5-bit code v widens to (v<<3)|(v>>2), and a 6-bit code widens to (v<<2)|(v>>4).
- R5: The four-colour case applies when endpoint 0, read as an unsigned 16-bit number, is greater than endpoint 1. Every other case, equality included, uses the three-colour case.
- R6: Mode 0, four-colour: entry 2 is (2*e0+e1)/3 and entry 3 is (2*e1+e0)/3, on expanded values, truncated.
- R7: Mode 0, three-colour: entry 2 is (e0+e1)/2, truncated. Mode 3 behaves exactly as mode 0.
- R8: Mode 2, four-colour: entry 2 is (43*e0+21*e1+32)>>6 and entry 3 is (43*e1+21*e0+32)>>6.
- R9: Mode 2, three-colour: entry 2 is (e0+e1+1)/2.
- R10: Mode 1, four-colour. Red and blue use ((2*n+f)*22)/8 on the raw 5-bit codes, with n the nearer endpoint (endpoint 0 for entry 2, endpoint 1 for entry 3). Green uses (256*lo + (hi-lo)/4 + 128 + (hi-lo)*80)/256 on expanded values, with signed division truncated toward zero. For entry 2, lo=e0 and hi=e1; for entry 3 they are swapped.
- R11: Mode 1, three-colour. Red and blue of entry 2 are ((c0+c1)*33)/8 on raw codes. Green is (256*e0 + (e1-e0)/4 + 128 + (e1-e0)*128)/256.
- R12: In the three-colour case, entry 3 is zero in all four channels. Every other entry has alpha 0xFF.
- R13: While `out_valid` is high and `out_ready` is low, `out_texel` and `out_valid` hold their values into the next cycle.
- R14: When `in_valid` is held high and `out_ready` is high, the next block is taken in the same cycle as the last texel of the current block. Its first texel appears on the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block offered |
| in_ready | output | 1 | Block can be taken |
| in_block | input | 64 | Endpoints and index word |
| in_mode | input | 2 | Interpolation convention for this block |
| out_valid | output | 1 | Texel available |
| out_ready | input | 1 | Sink takes the texel |
| out_texel | output | 32 | Decoded RGBA texel |

## Verification
Two events can fall in the same cycle: the handoff of a block's sixteenth texel and the acceptance of the next block. A phase that holds both `in_valid` and `out_ready` high forces them together on every block boundary. The bench predicts `in_ready` each cycle from its own texel count. It then checks that the first texel of the new block, computed from the new block's own mode, follows with no idle cycle. Random phases with sink stalls place the sixteenth texel both on stalled and on moving cycles, so the case where the handoff and acceptance do not coincide is covered too.

// File: rtl/bc1_dec_pkg.sv
package bc1_dec_pkg;

    typedef enum logic [1:0] {
        MODE_THIRDS = 2'd0,
        MODE_SCALED = 2'd1,
        MODE_BIASED = 2'd2,
        MODE_SPARE  = 2'd3
    } interp_mode_e;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] b;
        logic [7:0] g;
        logic [7:0] r;
    } texel_t;

    function automatic logic [7:0] widen5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] widen6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    // exact thirds, nearer endpoint weighted twice
    function automatic logic [7:0] thirds(input int near, input int far);
        return 8'((2 * near + far) / 3);
    endfunction

    // 6-bit fixed-point weights with rounding bias
    function automatic logic [7:0] biased(input int near, input int far);
        return 8'((43 * near + 21 * far + 32) >> 6);
    endfunction

    function automatic logic [7:0] half(input int x, input int y, input int bias);
        return 8'((x + y + bias) / 2);
    endfunction

    // raw 5-bit code rules for the scaled convention
    function automatic logic [7:0] scaled_rb4(input int near5, input int far5);
        return 8'(((2 * near5 + far5) * 22) / 8);
    endfunction

    function automatic logic [7:0] scaled_rb3(input int x5, input int y5);
        return 8'(((x5 + y5) * 33) / 8);
    endfunction

    // expanded green rule for the scaled convention, k selects the weight
    function automatic logic [7:0] scaled_g(input int lo, input int hi, input int k);
        int d;
        d = hi - lo;
        return 8'((256 * lo + d / 4 + 128 + d * k) / 256);
    endfunction

endpackage

// File: rtl/bc1_chan_interp.sv
module bc1_chan_interp
    import bc1_dec_pkg::*;
#(
    parameter bit WIDE = 1'b0
) (
    input  logic [5:0]   code0,
    input  logic [5:0]   code1,
    input  logic         four_mode,
    input  interp_mode_e mode,
    output logic [7:0]   ent0,
    output logic [7:0]   ent1,
    output logic [7:0]   ent2,
    output logic [7:0]   ent3
);

    int n0, n1, r0, r1;

    always_comb begin
        ent0 = WIDE ? widen6(code0) : widen5(code0[4:0]);
        ent1 = WIDE ? widen6(code1) : widen5(code1[4:0]);
        n0 = int'(ent0);
        n1 = int'(ent1);
        r0 = int'(code0);
        r1 = int'(code1);
        ent3 = 8'd0;
        case (mode)
            MODE_SCALED: begin
                if (four_mode) begin
                    ent2 = WIDE ? scaled_g(n0, n1, 80) : scaled_rb4(r0, r1);
                    ent3 = WIDE ? scaled_g(n1, n0, 80) : scaled_rb4(r1, r0);
                end else begin
                    ent2 = WIDE ? scaled_g(n0, n1, 128) : scaled_rb3(r0, r1);
                end
            end
            MODE_BIASED: begin
                if (four_mode) begin
                    ent2 = biased(n0, n1);
                    ent3 = biased(n1, n0);
                end else begin
                    ent2 = half(n0, n1, 1);
                end
            end
            default: begin
                if (four_mode) begin
                    ent2 = thirds(n0, n1);
                    ent3 = thirds(n1, n0);
                end else begin
                    ent2 = half(n0, n1, 0);
                end
            end
        endcase
    end

endmodule

// File: rtl/bc1_palette.sv
module bc1_palette
    import bc1_dec_pkg::*;
#(
    parameter int EP_W    = 16,
    parameter int ENTRIES = 4
) (
    input  logic [EP_W-1:0]          ep0,
    input  logic [EP_W-1:0]          ep1,
    input  interp_mode_e             mode,
    output logic                     four_mode,
    output texel_t [ENTRIES-1:0]     pal
);

    localparam int NCH = 3;

    logic [7:0] cv [NCH][ENTRIES];

    assign four_mode = (ep0 > ep1);

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        logic [5:0] code0, code1;
        if (ch == 0) begin : g_red
            assign code0 = {1'b0, ep0[15:11]};
            assign code1 = {1'b0, ep1[15:11]};
        end else if (ch == 1) begin : g_grn
            assign code0 = ep0[10:5];
            assign code1 = ep1[10:5];
        end else begin : g_blu
            assign code0 = {1'b0, ep0[4:0]};
            assign code1 = {1'b0, ep1[4:0]};
        end
        bc1_chan_interp #(.WIDE(ch == 1)) i_interp (
            .code0     (code0),
            .code1     (code1),
            .four_mode (four_mode),
            .mode      (mode),
            .ent0      (cv[ch][0]),
            .ent1      (cv[ch][1]),
            .ent2      (cv[ch][2]),
            .ent3      (cv[ch][3])
        );
    end

    for (genvar k = 0; k < ENTRIES; k++) begin : g_ent
        assign pal[k].r = cv[0][k];
        assign pal[k].g = cv[1][k];
        assign pal[k].b = cv[2][k];
        assign pal[k].a = (k == ENTRIES - 1 && !four_mode) ? 8'h00 : 8'hFF;
    end

endmodule

// File: rtl/bc1_texel_sel.sv
module bc1_texel_sel
    import bc1_dec_pkg::*;
#(
    parameter int TEXELS = 16,
    parameter int IDX_W  = 2,
    localparam int CNT_W = $clog2(TEXELS),
    localparam int WORD_W = TEXELS * IDX_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic [WORD_W-1:0]        idx_word,
    input  logic [CNT_W-1:0]         pos,
    input  texel_t [ENTRIES-1:0]     pal,
    output logic [IDX_W-1:0]         idx,
    output texel_t                   texel
);

    assign idx   = idx_word[pos * IDX_W +: IDX_W];
    assign texel = pal[idx];

endmodule

// File: rtl/bc1_block_decoder.sv
module bc1_block_decoder
    import bc1_dec_pkg::*;
#(
    parameter int TEXELS = 16,
    parameter int IDX_W  = 2,
    parameter int EP_W   = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [63:0] in_block,
    input  logic [1:0]  in_mode,
    output logic        out_valid,
    input  logic        out_ready,
    output logic [31:0] out_texel
);

    localparam int CNT_W   = $clog2(TEXELS);
    localparam int WORD_W  = TEXELS * IDX_W;
    localparam int BLK_W   = 2 * EP_W + WORD_W;
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TEXELS - 1);

    logic [BLK_W-1:0]  blk_q;
    interp_mode_e      mode_q;
    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_take;
    logic              accept;
    logic              four_mode;
    logic [IDX_W-1:0]  cur_idx;
    texel_t [ENTRIES-1:0] pal;
    texel_t            texel;

    assign last_take = busy_q && out_ready && (cnt_q == LAST);
    assign in_ready  = !busy_q || last_take;
    assign accept    = in_valid && in_ready;
    assign out_valid = busy_q;
    assign out_texel = texel;

    always_ff @(posedge clk) begin
        if (rst) begin
            blk_q  <= '0;
            mode_q <= MODE_THIRDS;
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            if (busy_q && out_ready) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
            if (accept) begin
                blk_q  <= in_block;
                mode_q <= interp_mode_e'(in_mode);
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end else if (last_take) begin
                busy_q <= 1'b0;
            end
        end
    end

    bc1_palette #(.EP_W(EP_W), .ENTRIES(ENTRIES)) i_palette (
        .ep0       (blk_q[EP_W-1:0]),
        .ep1       (blk_q[2*EP_W-1:EP_W]),
        .mode      (mode_q),
        .four_mode (four_mode),
        .pal       (pal)
    );

    bc1_texel_sel #(.TEXELS(TEXELS), .IDX_W(IDX_W)) i_sel (
        .idx_word (blk_q[BLK_W-1:2*EP_W]),
        .pos      (cnt_q),
        .pal      (pal),
        .idx      (cur_idx),
        .texel    (texel)
    );

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_texel)); // R13

    AST_NO_EARLY_TAKE: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(out_ready && cnt_q == LAST) |-> !in_ready); // R2

    AST_TAKE_STARTS_OUT: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid && cnt_q == '0); // R14

    AST_CLEAR_ENTRY: assert property (@(posedge clk) disable iff (rst)
        out_valid && !(blk_q[EP_W-1:0] > blk_q[2*EP_W-1:EP_W]) && cur_idx == IDX_W'(ENTRIES - 1)
        |-> out_texel == 32'd0); // R12

    AST_OPAQUE_ALPHA: assert property (@(posedge clk) disable iff (rst)
        out_valid && (four_mode || cur_idx != IDX_W'(ENTRIES - 1))
        |-> out_texel[31:24] == 8'hFF); // R12

    AST_ENDPOINT_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_valid && cur_idx == '0 |-> out_texel[15:8] == {blk_q[10:5], blk_q[10:9]}); // R4

endmodule

// File: tb/test_bc1_block_decoder.sv
`timescale 1ns/100ps
module test_bc1_block_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [63:0] in_block = '0;
    logic [1:0]  in_mode = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_texel;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bc1_block_decoder i_bc1_block_decoder (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_block(in_block), .in_mode(in_mode),
        .out_valid(out_valid), .out_ready(out_ready), .out_texel(out_texel)
    );

    // ---------------- reference model from the requirements ----------------
    function automatic int w5(int v); return (v << 3) | (v >> 2); endfunction
    function automatic int w6(int v); return (v << 2) | (v >> 4); endfunction

    function automatic int sg(int lo, int hi, int k);
        int d = hi - lo;
        return (256 * lo + d / 4 + 128 + d * k) / 256;
    endfunction

    // ch: 0 red, 1 green, 2 blue ; entry 0..3
    function automatic int chan_val(logic [15:0] a, logic [15:0] b, int md, int ch, int ent);
        int ca, cb, ea, eb;
        bit four = (a > b);
        bit green = (ch == 1);
        ca = (ch == 0) ? int'(a[15:11]) : (ch == 1) ? int'(a[10:5]) : int'(a[4:0]);
        cb = (ch == 0) ? int'(b[15:11]) : (ch == 1) ? int'(b[10:5]) : int'(b[4:0]);
        ea = green ? w6(ca) : w5(ca);
        eb = green ? w6(cb) : w5(cb);
        if (ent == 0) return ea;
        if (ent == 1) return eb;
        if (!four && ent == 3) return 0;
        if (md == 1) begin
            if (four) begin
                if (green) return (ent == 2) ? sg(ea, eb, 80) : sg(eb, ea, 80);
                return (ent == 2) ? ((2 * ca + cb) * 22) / 8 : ((2 * cb + ca) * 22) / 8;
            end
            return green ? sg(ea, eb, 128) : ((ca + cb) * 33) / 8;
        end
        if (md == 2) begin
            if (four) return (ent == 2) ? (43 * ea + 21 * eb + 32) >> 6 : (43 * eb + 21 * ea + 32) >> 6;
            return (ea + eb + 1) / 2;
        end
        if (four) return (ent == 2) ? (2 * ea + eb) / 3 : (2 * eb + ea) / 3;
        return (ea + eb) / 2;
    endfunction

    function automatic logic [31:0] model_texel(logic [63:0] blk, int md, int pos);
        int ent = int'(blk[32 + 2 * pos +: 2]);
        logic [7:0] r, g, b, a;
        r = 8'(chan_val(blk[15:0], blk[31:16], md, 0, ent));
        g = 8'(chan_val(blk[15:0], blk[31:16], md, 1, ent));
        b = 8'(chan_val(blk[15:0], blk[31:16], md, 2, ent));
        a = (ent == 3 && !(blk[15:0] > blk[31:16])) ? 8'h00 : 8'hFF;
        return {a, b, g, r};
    endfunction

    function automatic string tag_for(logic [63:0] blk, int md, int pos);
        int ent = int'(blk[32 + 2 * pos +: 2]);
        bit four = (blk[15:0] > blk[31:16]);
        if (blk[15:0] == blk[31:16] || blk[15:0] == blk[31:16] + 16'd1) return "R5";
        if (ent < 2) return "R4";
        if (!four && ent == 3) return "R12";
        if (md == 1) return four ? "R10" : "R11";
        if (md == 2) return four ? "R8" : "R9";
        return four ? "R6" : "R7";
    endfunction

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- bench-side tracking ----------------
    logic [63:0] cur_blk;
    int          cur_md;
    bit          cur_busy = 1'b0;
    int          cur_pos  = 0;
    bit          src_hold = 1'b0;
    int          blk_k    = 0;

    function automatic logic [63:0] gen_block(int k);
        logic [15:0] pa [4];
        logic [31:0] idx;
        pa[0] = 16'h8410; pa[1] = 16'hFFFF; pa[2] = 16'h0000; pa[3] = 16'h0001;
        idx = (k % 2 == 0) ? 32'hE4E4_E4E4 : $urandom;
        case ((k / 4) % 4)
            0: return {idx, pa[0], pa[0]};
            1: return {idx, pa[2], pa[1]};
            2: return {idx, pa[1], pa[2]};
            default: return {idx, pa[2], pa[3]};
        endcase
    endfunction

    // one cycle: inputs already driven after the falling edge
    task automatic step();
        bit exp_rdy;
        logic [31:0] exp_t;
        #1;
        exp_rdy = !cur_busy || (cur_pos == 15 && out_ready);
        check(in_ready == exp_rdy, (cur_busy && cur_pos == 15) ? "R14" : "R2",
              32'(in_ready), 32'(exp_rdy));
        check(out_valid == cur_busy, "R3", 32'(out_valid), 32'(cur_busy));
        if (cur_busy && out_valid) begin
            exp_t = model_texel(cur_blk, cur_md, cur_pos);
            check(out_texel == exp_t, out_ready ? tag_for(cur_blk, cur_md, cur_pos) : "R13",
                  out_texel, exp_t);
        end
        if (cur_busy && out_ready) begin
            cur_pos++;
            if (cur_pos == 16) begin
                cur_busy = 1'b0;
                cur_pos  = 0;
            end
        end
        if (in_valid && in_ready) begin
            cur_blk  = in_block;
            cur_md   = (int'(in_mode) == 3) ? 0 : int'(in_mode);
            cur_busy = 1'b1;
            cur_pos  = 0;
            src_hold = 1'b0;
            blk_k++;
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic drive_source(bit force_valid);
        if (!src_hold) begin
            if (force_valid || ($urandom % 10) < 7) begin
                in_valid = 1'b1;
                if (blk_k < 16) begin
                    in_block = gen_block(blk_k);
                    in_mode  = 2'(blk_k % 4);
                end else begin
                    in_block = {$urandom, $urandom};
                    in_mode  = 2'($urandom % 4);
                end
                src_hold = 1'b1;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin : watchdog
        #(4 * 150000);
        if (!finished) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", blk_k, 70);
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'd1234));
        @(negedge clk);
        @(negedge clk);
        // R1: reset values
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);
        check(in_ready == 1'b1, "R1", 32'(in_ready), 32'd1);
        rst = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", 32'(out_valid), 32'd0);

        // directed then random blocks with sink stalls
        while (blk_k < 40) begin
            drive_source(1'b0);
            out_ready = (($urandom % 4) != 0);
            step();
        end
        // back-to-back phase: R14
        while (blk_k < 70) begin
            drive_source(1'b1);
            out_ready = 1'b1;
            step();
        end
        in_valid = 1'b0;
        out_ready = 1'b1;
        for (int i = 0; i < 20; i++) step();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule